// File: doc/BRIEF.md
# Per-Pin Secure Access Filter for a GPIO Port

This block stands between the bus and a sixteen-pin GPIO register file. It holds the per-pin secure-configuration register and enforces it. Every access carries a register selector and a secure attribute. The filter passes the access on one clock later. It adds a write-enable mask that clears every bit belonging to a pin a nonsecure master may not touch. It also zeroes the same bits in the read data coming back from the register file. Privilege plays no part: the bus does not give it to the filter.

The mask is built per pin and widened to the field width of the selected register. Single-bit fields use one mask bit per pin. Two-bit fields repeat each pin bit twice. The set/clear register repeats the mask in both halves. The two alternate-function registers repeat each pin bit four times, one register for each half of the port. A global security-enable input turns the scheme off. While it is low, every pin counts as nonsecure and the secure-configuration register reads as zero and ignores writes. A flag tells the clock and reset controller whether any pin is currently secure.

Top module: `gpio_secure_filter`

## Requirements
- R1: After a synchronous reset, every secure-configuration bit is 1, out_valid, out_wmask and out_rdata are zero, and port_ctl_secure is 0.
- R2: With sec_en high, a nonsecure access gets zero write-mask bits and zero read-data bits on every field of a secure pin. Fields of nonsecure pins pass unchanged.
- R3: A secure access gets an all-ones write mask and unmodified read data on every register-file register.
- R4: Register codes 0 (mode), 2 (speed) and 3 (pull) have 2-bit fields: bits 2p+1:2p belong to pin p. Codes 1 (output type), 4 (input data), 5 (output data), 7 (lock), 10 (clear-only) and 11 (speed-optimisation) have 1-bit fields in bits 15:0. For these codes bits 31:16 are not filtered.
- R5: Code 8 maps pin p (p < 8) to bits 4p+3:4p. Code 9 maps pin p+8 to the same bits.
- R6: Code 6 (set/clear) maps pin p to bit p and to bit p+16, so both a set and a clear request from a nonsecure master are dropped on a secure pin.
- R7: Code 12 is the secure-configuration register, with pin bits in 15:0 and reads of 31:16 as zero. With sec_en high, only a secure write updates it. A nonsecure write leaves it unchanged. Any master may read it.
- R8: With sec_en low, all pins are treated as nonsecure, code 12 reads zero, and writes to it are ignored. The stored value reappears when sec_en returns high.
- R9: port_ctl_secure equals sec_en AND (any stored secure bit), registered one cycle.
- R10: The outputs out_valid, out_write, out_secure, out_reg and out_wdata repeat the access one cycle later. out_wmask is zero unless the access was a valid write. out_rdata is zero unless it was a valid read.
- R11: Codes 13 to 15 select no register and give a zero write mask and zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en | input | 1 | Global security enable |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_secure | input | 1 | Access issued by a secure master |
| acc_reg | input | 4 | Register code |
| acc_wdata | input | 32 | Write data |
| file_rdata | input | 32 | Raw read data from the register file for acc_reg |
| out_valid | output | 1 | Forwarded access valid |
| out_write | output | 1 | Forwarded write flag |
| out_secure | output | 1 | Forwarded secure attribute |
| out_reg | output | 4 | Forwarded register code |
| out_wdata | output | 32 | Forwarded write data |
| out_wmask | output | 32 | Per-bit write enable for the register file |
| out_rdata | output | 32 | Filtered read data |
| port_ctl_secure | output | 1 | Clock/reset control of the port must be secure |

## Verification
The bench goes after the field-width expansion on every register class. A design that widened the mask wrongly would let a nonsecure master change half of a two-bit mode field, or one alternate-function nibble of a secure pin. The bench also checks set/clear writes on secure pins, which a design masking only the lower half would let clear a secure output. It exercises the global-disable case, where a design that kept reading the stored value would leak the secure map, and one that still accepted writes would lose it when security returns. It checks nonsecure writes to the configuration register, which must leave the stored value unchanged.

// File: rtl/gsf_pkg.sv
package gsf_pkg;

  typedef enum logic [3:0] {
    RC_MODE   = 4'd0,
    RC_OTYPE  = 4'd1,
    RC_SPEED  = 4'd2,
    RC_PULL   = 4'd3,
    RC_IN     = 4'd4,
    RC_OUT    = 4'd5,
    RC_SETCLR = 4'd6,
    RC_LOCK   = 4'd7,
    RC_AFLO   = 4'd8,
    RC_AFHI   = 4'd9,
    RC_CLR    = 4'd10,
    RC_HSLV   = 4'd11,
    RC_SECCFG = 4'd12
  } reg_code_e;

  typedef enum logic [2:0] {
    FLD_W1,
    FLD_W2,
    FLD_SR,
    FLD_AFLO,
    FLD_AFHI,
    FLD_CFG,
    FLD_NONE
  } fld_e;

  function automatic fld_e fld_of(input logic [3:0] code);
    case (code)
      RC_MODE, RC_SPEED, RC_PULL:                    return FLD_W2;
      RC_OTYPE, RC_IN, RC_OUT, RC_LOCK, RC_CLR, RC_HSLV: return FLD_W1;
      RC_SETCLR:                                     return FLD_SR;
      RC_AFLO:                                       return FLD_AFLO;
      RC_AFHI:                                       return FLD_AFHI;
      RC_SECCFG:                                     return FLD_CFG;
      default:                                       return FLD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sf_seccfg.sv
module sf_seccfg #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_en,
  input  logic             wr_en,
  input  logic             wr_secure,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] cfg_q,
  output logic [NPINS-1:0] eff,
  output logic [DW-1:0]    rd_word
);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '1;
    else if (wr_en && sec_en && wr_secure) cfg_q <= wdata;
  end

  assign eff     = sec_en ? cfg_q : '0;
  assign rd_word = sec_en ? {{(DW-NPINS){1'b0}}, cfg_q} : '0;

  // R7 / R8: a write that is not secure, or arrives while disabled, keeps the map
  a_r7_unauth_write_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(sec_en && wr_secure)) |=> $stable(cfg_q));

endmodule

// File: rtl/sf_mask_expand.sv
module sf_mask_expand
  import gsf_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int DW    = 32,
  parameter int AFW   = 4
) (
  input  logic [NPINS-1:0] blk,
  input  fld_e             fld,
  output logic [DW-1:0]    allow
);

  localparam int AF_PER = DW / AFW;

  logic [NPINS-1:0] ok;
  logic [DW-1:0]    m_w1, m_w2, m_sr, m_aflo, m_afhi;

  assign ok   = ~blk;
  assign m_w1 = {{(DW-NPINS){1'b1}}, ok};
  assign m_sr = {ok, ok};

  for (genvar p = 0; p < NPINS; p++) begin : g_w2
    assign m_w2[2*p +: 2] = {2{ok[p]}};
  end

  for (genvar j = 0; j < AF_PER; j++) begin : g_af
    assign m_aflo[j*AFW +: AFW] = {AFW{ok[j]}};
    assign m_afhi[j*AFW +: AFW] = {AFW{ok[j+AF_PER]}};
  end

  always_comb begin
    case (fld)
      FLD_W1:   allow = m_w1;
      FLD_W2:   allow = m_w2;
      FLD_SR:   allow = m_sr;
      FLD_AFLO: allow = m_aflo;
      FLD_AFHI: allow = m_afhi;
      default:  allow = '0;
    endcase
  end

endmodule

// File: rtl/gpio_secure_filter.sv
module gpio_secure_filter
  import gsf_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int DW    = 32,
  parameter int AFW   = 4,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_en,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_secure,
  input  logic [RW-1:0] acc_reg,
  input  logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] file_rdata,
  output logic          out_valid,
  output logic          out_write,
  output logic          out_secure,
  output logic [RW-1:0] out_reg,
  output logic [DW-1:0] out_wdata,
  output logic [DW-1:0] out_wmask,
  output logic [DW-1:0] out_rdata,
  output logic          port_ctl_secure
);

  logic [NPINS-1:0] cfg_q, eff, blk;
  logic [DW-1:0]    cfg_rd, allow, rd_sel;
  fld_e             fld;
  logic             cfg_wr;

  assign fld    = fld_of(acc_reg);
  assign cfg_wr = acc_valid && acc_write && (fld == FLD_CFG);

  sf_seccfg #(.NPINS(NPINS), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .sec_en(sec_en),
    .wr_en(cfg_wr), .wr_secure(acc_secure),
    .wdata(acc_wdata[NPINS-1:0]),
    .cfg_q(cfg_q), .eff(eff), .rd_word(cfg_rd)
  );

  assign blk = acc_secure ? '0 : eff;

  sf_mask_expand #(.NPINS(NPINS), .DW(DW), .AFW(AFW)) u_exp (
    .blk(blk), .fld(fld), .allow(allow)
  );

  always_comb begin
    if (fld == FLD_CFG)       rd_sel = cfg_rd;
    else if (fld == FLD_NONE) rd_sel = '0;
    else                      rd_sel = file_rdata & allow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_write       <= 1'b0;
      out_secure      <= 1'b0;
      out_reg         <= '0;
      out_wdata       <= '0;
      out_wmask       <= '0;
      out_rdata       <= '0;
      port_ctl_secure <= 1'b0;
    end else begin
      out_valid       <= acc_valid;
      out_write       <= acc_write;
      out_secure      <= acc_secure;
      out_reg         <= acc_reg;
      out_wdata       <= acc_wdata;
      out_wmask       <= (acc_valid && acc_write) ? allow : '0;
      out_rdata       <= (acc_valid && !acc_write) ? rd_sel : '0;
      port_ctl_secure <= sec_en && (|cfg_q);
    end
  end

  // R3: secure writes to the mode register are never filtered
  a_r3_secure_mode_open: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_write && out_secure && out_reg == RW'(RC_MODE)) |-> (&out_wmask));

  // R4: two-bit fields are always enabled as whole pairs
  a_r4_pair_whole: assert property (@(posedge clk) disable iff (rst)
    (out_reg == RW'(RC_MODE) || out_reg == RW'(RC_SPEED) || out_reg == RW'(RC_PULL)) |->
    ((out_wmask & 32'h5555_5555) == ((out_wmask >> 1) & 32'h5555_5555)));

  // R6: set and clear halves carry the same pin mask
  a_r6_sr_halves: assert property (@(posedge clk) disable iff (rst)
    (out_reg == RW'(RC_SETCLR)) |-> (out_wmask[DW-1:DW/2] == out_wmask[DW/2-1:0]));

  // R8: configuration register reads zero when security was off
  a_r8_off_cfg_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_write && out_reg == RW'(RC_SECCFG) && $past(!sec_en)) |-> (out_rdata == '0));

  // R9: the control-secure flag needs security enabled in the prior cycle
  a_r9_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
    port_ctl_secure |-> $past(sec_en));

  // R10: no write enables without a valid write
  a_r10_idle_no_mask: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_write) |-> (out_wmask == '0));

  // R11: unused codes expose nothing
  a_r11_unused_code: assert property (@(posedge clk) disable iff (rst)
    (out_reg > RW'(RC_SECCFG)) |-> (out_wmask == '0 && out_rdata == '0));

endmodule

// File: tb/tb_gpio_secure_filter.sv
`timescale 1ns/1ps
module tb_gpio_secure_filter;

  logic        clk = 1'b0;
  logic        rst;
  logic        sec_en, acc_valid, acc_write, acc_secure;
  logic [3:0]  acc_reg;
  logic [31:0] acc_wdata, file_rdata;
  logic        out_valid, out_write, out_secure, port_ctl_secure;
  logic [3:0]  out_reg;
  logic [31:0] out_wdata, out_wmask, out_rdata;

  int errors = 0;
  int checks = 0;
  logic [15:0] model_cfg;

  always #2.5 clk = ~clk;

  gpio_secure_filter dut (
    .clk(clk), .rst(rst), .sec_en(sec_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_secure(acc_secure), .acc_reg(acc_reg),
    .acc_wdata(acc_wdata), .file_rdata(file_rdata),
    .out_valid(out_valid), .out_write(out_write), .out_secure(out_secure),
    .out_reg(out_reg), .out_wdata(out_wdata), .out_wmask(out_wmask),
    .out_rdata(out_rdata), .port_ctl_secure(port_ctl_secure)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bit-by-bit enable computed from the register layout in the requirements
  function automatic logic [31:0] exp_allow(input logic [3:0] code, input logic [15:0] blocked);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) begin
      case (code)
        4'd0, 4'd2, 4'd3:                m[b] = !blocked[b/2];
        4'd1, 4'd4, 4'd5, 4'd7, 4'd10, 4'd11: m[b] = (b >= 16) ? 1'b1 : !blocked[b];
        4'd6:                            m[b] = !blocked[b%16];
        4'd8:                            m[b] = !blocked[b/4];
        4'd9:                            m[b] = !blocked[b/4 + 8];
        default:                         m[b] = 1'b0;
      endcase
    end
    return m;
  endfunction

  task automatic access(input string tag, input logic en, input logic wr, input logic sec,
                        input logic [3:0] code, input logic [31:0] wd, input logic [31:0] fr);
    logic [15:0] blocked;
    logic [31:0] e_mask, e_rd;
    logic        e_flag;
    sec_en = en; acc_valid = 1'b1; acc_write = wr; acc_secure = sec;
    acc_reg = code; acc_wdata = wd; file_rdata = fr;
    blocked = (en && !sec) ? model_cfg : 16'h0;
    e_mask  = wr ? exp_allow(code, blocked) : 32'h0;
    if (wr)               e_rd = 32'h0;
    else if (code == 4'd12) e_rd = en ? {16'h0, model_cfg} : 32'h0;
    else                  e_rd = fr & exp_allow(code, blocked);
    e_flag = en && (model_cfg != 16'h0);
    if (wr && code == 4'd12 && en && sec) model_cfg = wd[15:0];
    @(posedge clk); @(negedge clk);
    chk({tag, " wmask"}, out_wmask, e_mask);
    chk({tag, " rdata"}, out_rdata, e_rd);
    chk("R9 flag", {31'h0, port_ctl_secure}, {31'h0, e_flag});
    chk("R10 fwd", {out_valid, out_write, out_secure, out_reg, 25'h0},
        {1'b1, wr, sec, code, 25'h0});
    chk("R10 wdata", out_wdata, wd);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_cfg = 16'hFFFF;
    rst = 1'b1; sec_en = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_secure = 1'b0;
    acc_reg = 4'd0; acc_wdata = '0; file_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state of outputs
    chk("R1 valid", {31'h0, out_valid}, 32'h0);
    chk("R1 wmask", out_wmask, 32'h0);
    chk("R1 rdata", out_rdata, 32'h0);
    chk("R1 flag", {31'h0, port_ctl_secure}, 32'h0);
    rst = 1'b0;
    // R1: all pins start secure
    access("R1 cfg read", 1, 0, 0, 4'd12, 32'h0, 32'hDEAD_BEEF);
    // R2: everything blocked for nonsecure master at reset
    access("R2 mode ns", 1, 1, 0, 4'd0, 32'hFFFF_FFFF, 32'h0);
    // R7: nonsecure write to configuration ignored
    access("R7 ns write", 1, 1, 0, 4'd12, 32'h0000_0000, 32'h0);
    access("R7 readback", 1, 0, 0, 4'd12, 32'h0, 32'h0);
    access("R7 sec write", 1, 1, 1, 4'd12, 32'hFFFF_00F1, 32'h0);
    access("R7 readback2", 1, 0, 1, 4'd12, 32'h0, 32'h0);
    // R4, R5, R6 on mixed map 0x00F1
    access("R4 mode ns", 1, 1, 0, 4'd0, 32'hFFFF_FFFF, 32'h0);
    access("R4 otype rd", 1, 0, 0, 4'd1, 32'h0, 32'hFFFF_FFFF);
    access("R5 aflo ns", 1, 1, 0, 4'd8, 32'h0, 32'h0);
    access("R5 afhi ns", 1, 0, 0, 4'd9, 32'h0, 32'hFFFF_FFFF);
    access("R6 setclr ns", 1, 1, 0, 4'd6, 32'hFFFF_FFFF, 32'h0);
    access("R3 sec mode", 1, 1, 1, 4'd0, 32'h1234_5678, 32'h0);
    access("R11 unused", 1, 0, 1, 4'd14, 32'h0, 32'hFFFF_FFFF);
    // R8: disabled security
    access("R8 cfg off", 0, 0, 1, 4'd12, 32'h0, 32'h0);
    access("R8 write off", 0, 1, 1, 4'd12, 32'h0000_1234, 32'h0);
    access("R8 pins open", 0, 1, 0, 4'd3, 32'h0, 32'h0);
    access("R8 restored", 1, 0, 0, 4'd12, 32'h0, 32'h0);
    // R10: idle cycle clears masks
    acc_valid = 1'b0; acc_write = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 idle", {out_valid, 31'h0} | out_wmask, 32'h0);
    // random traffic covering R2..R11
    for (int i = 0; i < 800; i++) begin
      logic en = ($urandom % 10) != 0;
      logic [3:0] code = 4'($urandom % 16);
      logic [31:0] wd = $urandom;
      if (code == 4'd12 && ($urandom % 3) == 0) wd[15:0] = 16'h0;
      access("R2 random", en, 1'($urandom), 1'($urandom), code, wd, $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule